// File: doc/BRIEF.md
# Power-On Reset and Output Mute Sequencer

This block controls start-up of a converter's digital sample output. A supply-good input, which stands in for a comparator that watches the supply voltage, starts the sequence. While that input is low, the block drives its internal reset output active, forces the sample output to zero and holds the valid flag low. All of this takes effect at once, with no clock edge needed.

When supply-good goes high, the input passes through a two-flop synchronizer. The internal reset then stays active for a fixed number of system clocks. Next comes a mute phase that is counted on a sample-rate strobe. The output stays at zero until a fixed number of strobes have been seen. After that the block enters its run state. In run, the incoming sample word goes straight to the output and the valid flag is high.

If supply-good falls at any point, the block goes back to reset. Both counts start again from zero when the supply comes back. With the default parameters, reset is held for 1024 clocks and the output is muted for 4480 sample periods.

Top module: `por_mute_seq`

## Requirements
- R1: While `supply_ok` is low, `rst_n_int` is 0, `dout` is all zeros and `dout_valid` is 0. This holds immediately when `supply_ok` falls, with no clock edge needed.
- R2: `supply_ok` is synchronized by two flip-flops before the hold count uses it.
- R3: After `supply_ok` rises, `rst_n_int` first reads 1 after the (HOLD_CLKS+2)-th rising clock edge. It reads 0 after every earlier edge.
- R4: `dout_valid` rises at the edge that samples the MUTE_SAMPLES-th high `sample_stb` seen while `rst_n_int` is already 1. Cycles without the strobe do not advance the mute count.
- R5: While `rst_n_int` is 1 and `dout_valid` is 0 (the mute phase), `dout` is all zeros whatever `din` carries.
- R6: Once `dout_valid` is 1, `dout` equals `din` in the same cycle, and `dout_valid` stays 1 for as long as `supply_ok` stays high.
- R7: Strobes that arrive while `rst_n_int` is 0 are not counted toward the mute interval.
- R8: When `supply_ok` falls and later rises again, the hold count and the mute count both restart from zero. The phase in which the drop happened makes no difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| supply_ok | input | 1 | Raw supply-good indication; low means supply is below threshold |
| sample_stb | input | 1 | One-cycle pulse per sample period |
| din | input | DATA_W | Incoming sample word |
| rst_n_int | output | 1 | Internal reset, active low |
| dout | output | DATA_W | Gated sample output |
| dout_valid | output | 1 | Output data is valid |

## Verification
Each result has its own timing.
- **R1:** the effect of a supply drop is due at once, so it is sampled 1 ns after the drop with no clock edge in between.
- **R3:** the reset release is due exactly HOLD_CLKS+2 edges after the rise. The bench counts edges from the rise and checks `rst_n_int` after every edge.
- **R4:** the valid flag is due at the edge that samples the last mute strobe. The bench counts only the strobes it drove at edges where the reset was already released.
- **R5 and R6:** `dout` is a combinational gate, so it is compared with the `din` value driven in that same cycle.

All outputs are sampled at the falling edge, after inputs have been changed there. The bench sweeps the supply-drop point across every cycle of the whole sequence.

// File: rtl/por_mute_seq.sv
module por_mute_seq #(
  parameter int DATA_W       = 24,
  parameter int HOLD_CLKS    = 1024,
  parameter int MUTE_SAMPLES = 4480
) (
  input  logic              clk,
  input  logic              supply_ok,
  input  logic              sample_stb,
  input  logic [DATA_W-1:0] din,
  output logic              rst_n_int,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);

  localparam int CNT_MAX = (HOLD_CLKS > MUTE_SAMPLES) ? HOLD_CLKS : MUTE_SAMPLES;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CLKS - 1);
  localparam logic [CW-1:0] MUTE_LAST = CW'(MUTE_SAMPLES - 1);

  typedef enum logic [1:0] {S_RESET, S_MUTE, S_RUN} state_t;

  logic [1:0]    sync_q;
  logic          good;
  state_t        state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge supply_ok)
    if (!supply_ok) sync_q <= '0;
    else            sync_q <= {sync_q[0], 1'b1};

  assign good = sync_q[1];

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      state <= S_RESET;
      cnt   <= '0;
    end else begin
      case (state)
        S_RESET:
          if (good) begin
            if (cnt == HOLD_LAST) begin
              state <= S_MUTE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        S_MUTE:
          if (sample_stb) begin
            if (cnt == MUTE_LAST) state <= S_RUN;
            else                  cnt   <= cnt + CW'(1);
          end
        S_RUN:   state <= S_RUN;
        default: state <= S_RESET;
      endcase
    end
  end

  assign rst_n_int  = (state != S_RESET);
  assign dout_valid = (state == S_RUN);
  assign dout       = dout_valid ? din : '0;

endmodule

module por_mute_seq_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              supply_ok,
  input logic              sample_stb,
  input logic [DATA_W-1:0] din,
  input logic              rst_n_int,
  input logic [DATA_W-1:0] dout,
  input logic              dout_valid
);

  p_mute_zero_r5: assert property (@(posedge clk) disable iff (!supply_ok)
    !dout_valid |-> dout == '0);

  p_pass_r6: assert property (@(posedge clk) disable iff (!supply_ok)
    dout_valid |-> dout == din);

  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!supply_ok)
    dout_valid |=> dout_valid);

  p_valid_after_rst_r4: assert property (@(posedge clk) disable iff (!supply_ok)
    dout_valid |-> rst_n_int);

  p_valid_on_stb_r4: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(dout_valid) |-> $past(sample_stb) && $past(rst_n_int));

  p_rst_release_r3: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(rst_n_int) |-> !dout_valid);

  p_rst_hold_r8: assert property (@(posedge clk) disable iff (!supply_ok)
    rst_n_int |=> rst_n_int);

endmodule

bind por_mute_seq por_mute_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .supply_ok(supply_ok), .sample_stb(sample_stb), .din(din),
  .rst_n_int(rst_n_int), .dout(dout), .dout_valid(dout_valid)
);

// File: tb/por_mute_seq_test.sv
module por_mute_seq_test;
  localparam int CLK_P = 10;
  localparam int W = 8;
  localparam int H = 6;
  localparam int M = 4;
  localparam int T = H + 2 + 3 * M + 8;

  logic         clk = 1'b0;
  logic         supply_ok = 1'b0;
  logic         sample_stb = 1'b0;
  logic [W-1:0] din = '0;
  logic         rst_n_int;
  logic [W-1:0] dout;
  logic         dout_valid;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  por_mute_seq #(.DATA_W(W), .HOLD_CLKS(H), .MUTE_SAMPLES(M)) uut (
    .clk(clk), .supply_ok(supply_ok), .sample_stb(sample_stb), .din(din),
    .rst_n_int(rst_n_int), .dout(dout), .dout_valid(dout_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_next();
    cyc++;
    sample_stb = (cyc % 3 == 0);
    din = W'(cyc * 37 + 5);
  endtask

  task automatic check_off(input string req);
    chk(rst_n_int == 1'b0, req, int'(rst_n_int), 0);
    chk(dout == '0, req, int'(dout), 0);
    chk(dout_valid == 1'b0, req, int'(dout_valid), 0);
  endtask

  task automatic run_seq(input int d);
    int  e = 0;
    int  nstb = 0;
    bit  s;
    bit  ev;
    supply_ok = 1'b1;
    for (int i = 0; i < d; i++) begin
      @(posedge clk);
      e++;
      s = sample_stb;
      if (e >= H + 3 && s) nstb++;
      @(negedge clk);
      drive_next();
      #1;
      ev = (nstb >= M);
      chk(rst_n_int == (e >= H + 2), "R3", int'(rst_n_int), int'(e >= H + 2));
      chk(dout_valid == ev, "R4/R7", int'(dout_valid), int'(ev));
      if (ev) chk(dout == din, "R6", int'(dout), int'(din));
      else    chk(dout == '0, "R5", int'(dout), 0);
    end
    supply_ok = 1'b0;
    #1;
    check_off("R1");
    repeat (2) begin
      @(negedge clk);
      drive_next();
      #1;
      check_off("R1");
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      drive_next();
      #1;
      check_off("R1");
    end
    // R2 R8: sweep the drop point across every cycle of the sequence
    for (int d = 1; d <= T; d++) begin
      @(negedge clk);
      run_seq(d);
    end
    @(negedge clk);
    run_seq(T + 20);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule